// File: doc/BRIEF.md
# Serial ADC Readout Master

This block reads conversion results from a 12-bit serial successive-approximation converter. It drives an active-low chip select and a serial clock that it divides down from the system clock. The converter uses the same serial clock both to convert and to shift its result out. Pulling chip select low starts a conversion. The converter then returns a fixed 16-bit word: four zero bits come first, then the 12-bit result, most significant bit first.

A single-cycle `start_i` request opens a frame. The master samples the data line on each rising serial-clock edge and stops after the sixteenth bit. It then raises chip select and pulses `valid_o` with the 12-bit result. In the same cycle it raises `frame_err_o` if any of the four leading bits was not zero. Before the next frame, chip select stays high for a minimum time set by a parameter. A request that arrives while a frame or that high time is in progress is held and served afterwards.

Top module: `adc_rd_master`

## Requirements
- R1: After reset, `cs_no` is high, `sclk_o` is low, and `valid_o`, `frame_err_o` and `busy_o` are low.
- R2: `cs_no` falls only while `sclk_o` is low. The first rising edge of `sclk_o` comes exactly HALF_DIV system cycles after `cs_no` falls.
- R3: While `cs_no` is low, successive rising edges of `sclk_o` are 2*HALF_DIV system cycles apart. While `cs_no` is high, `sclk_o` is low.
- R4: Each frame has exactly 16 rising edges of `sclk_o`. `sdata_i` is sampled on each rising edge. The first sample is frame bit 15 and the last is frame bit 0.
- R5: When a frame ends, `cs_no` rises and `valid_o` pulses high for one cycle in the same cycle. `data_o` then equals frame bits 11:0 and holds until the next pulse.
- R6: `frame_err_o` is updated together with `valid_o`. It is 1 exactly when any of frame bits 15:12 is 1.
- R7: Between two frames, `cs_no` stays high for at least CS_GAP system cycles.
- R8: A `start_i` pulse that arrives while `busy_o` is high is held. One new frame starts after the current frame and its high time. Further pulses in that window do not add more frames.
- R9: `busy_o` is high whenever `cs_no` is low, and stays high through the minimum high time that follows a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to read one conversion |
| sdata_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Chip select, active low; its falling edge starts a conversion |
| sclk_o | output | 1 | Serial and conversion clock, low when idle |
| busy_o | output | 1 | A frame or its minimum high time is in progress |
| valid_o | output | 1 | One-cycle strobe when a new result is available |
| data_o | output | 12 | Last conversion result |
| frame_err_o | output | 1 | A leading bit of the last frame was not zero |

## Verification
A behavioural converter model returns a set of result words. All-zero and all-one results show whether the master frames exactly 16 bits. The alternating patterns 0x555 and 0xAAA expose bit-order and off-by-one shift errors, and 0xABC catches a swapped nibble. Words with a single stray leading bit, either at the top or just above the result, show whether the error flag covers every leading position without corrupting the 12-bit data. A directed back-to-back sequence sends repeated requests during a frame. It checks that exactly one extra frame follows, and only after the minimum chip-select high time.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/adc_rd_div.sv
module adc_rd_div #(
  parameter int unsigned HALF_DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign word_o = sh_q;
endmodule

// File: rtl/adc_rd_master.sv
module adc_rd_master #(
  parameter int unsigned HALF_DIV = 12,
  parameter int unsigned CS_GAP   = 8,
  parameter int unsigned RES_W    = 12,
  parameter int unsigned LEAD_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sdata_i,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [RES_W-1:0] data_o,
  output logic             frame_err_o
);
  import adc_rd_pkg::*;

  localparam int unsigned FRAME_W = RES_W + LEAD_W;
  localparam int unsigned BCNT_W  = $clog2(FRAME_W + 1);
  localparam int unsigned GCNT_W  = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [BCNT_W-1:0] BLAST = BCNT_W'(FRAME_W);
  localparam logic [GCNT_W-1:0] GLAST = GCNT_W'(CS_GAP - 1);

  rd_state_e          state_q;
  logic               cs_q, sclk_q, pend_q, valid_q, err_q;
  logic [BCNT_W-1:0]  bcnt_q;
  logic [GCNT_W-1:0]  gcnt_q;
  logic [RES_W-1:0]   data_q;
  logic [FRAME_W-1:0] word;
  logic               tick, shift_en, req;

  assign req      = start_i || pend_q;
  assign shift_en = (state_q == ST_XFER) && tick && !sclk_q;

  adc_rd_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_XFER),
    .tick_o (tick)
  );

  adc_rd_shift #(.W(FRAME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (shift_en),
    .bit_i  (sdata_i),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      bcnt_q  <= '0;
      gcnt_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (state_q != ST_IDLE && start_i) pend_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (req) begin
            state_q <= ST_XFER;
            cs_q    <= 1'b0;   // conversion starts here, sclk is low
            bcnt_q  <= '0;
            pend_q  <= 1'b0;
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              bcnt_q <= bcnt_q + 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bcnt_q == BLAST) begin
                state_q <= ST_GAP;
                cs_q    <= 1'b1;
                valid_q <= 1'b1;
                data_q  <= word[RES_W-1:0];
                err_q   <= |word[FRAME_W-1:RES_W];
                gcnt_q  <= '0;
              end
            end
          end
        end
        ST_GAP: begin
          if (gcnt_q == GLAST) state_q <= ST_IDLE;
          else                 gcnt_q  <= gcnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no       = cs_q;
  assign sclk_o      = sclk_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign valid_o     = valid_q;
  assign data_o      = data_q;
  assign frame_err_o = err_q;
endmodule

// File: rtl/adc_rd_master_chk.sv
module adc_rd_master_chk #(
  parameter int unsigned CS_GAP = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sclk_o,
  input logic busy_o,
  input logic valid_o
);
  localparam int unsigned HW = $clog2(CS_GAP + 2) + 1;
  localparam logic [HW-1:0] HMAX = {HW{1'b1}};

  logic [HW-1:0] hi_cnt;
  logic          seen_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt     <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (valid_o) seen_frame <= 1'b1;
      if (!cs_no)             hi_cnt <= '0;
      else if (hi_cnt != HMAX) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_CS_FALL_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !sclk_o); // R2
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_no)); // R5
  AST_BUSY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o); // R9
  AST_CS_MIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && seen_frame) |-> (hi_cnt >= HW'(CS_GAP))); // R7
endmodule

bind adc_rd_master adc_rd_master_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_no   (cs_no),
  .sclk_o  (sclk_o),
  .busy_o  (busy_o),
  .valid_o (valid_o)
);

// File: tb/sim_adc_rd_master.sv
module sim_adc_rd_master;
  localparam int HALF = 12;
  localparam int GAP  = 8;
  localparam int NV   = 8;
  localparam logic [15:0] VEC [NV] = '{
    16'h0ABC, 16'h0000, 16'h0FFF, 16'h0555,
    16'h0AAA, 16'h8123, 16'h1F0F, 16'h4800
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sdata = 1'b0;
  logic cs_n, sclk, busy, valid, ferr;
  logic [11:0] data;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  adc_rd_master #(.HALF_DIV(HALF), .CS_GAP(GAP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sdata_i(sdata),
    .cs_no(cs_n), .sclk_o(sclk), .busy_o(busy), .valid_o(valid),
    .data_o(data), .frame_err_o(ferr)
  );

  // behavioural converter: frame loaded at cs fall, advanced on sclk fall
  logic [15:0] model_word = 16'h0;
  logic [15:0] shw = 16'h0;
  always @(negedge cs_n) begin
    shw = model_word;
    sdata = shw[15];
  end
  always @(negedge sclk) if (!cs_n) begin
    shw = {shw[14:0], 1'b0};
    sdata = shw[15];
  end

  // port monitor, sampled on falling clock edge
  int n = 0, fall_cnt = 0, rises = 0, d_first = 0, last_rise = 0;
  int period_bad = 0, hi_run = 0, last_hi = 0, valid_cnt = 0;
  logic sclk_at_fall = 1'b0, prev_cs = 1'b1, prev_sclk = 1'b0;
  always @(negedge clk) begin
    n++;
    if (valid) valid_cnt++;
    if (prev_cs && !cs_n) begin
      fall_cnt++;
      sclk_at_fall = sclk;
      rises = 0;
      last_hi = hi_run;
      last_rise = n;
    end
    if (cs_n) hi_run++; else hi_run = 0;
    if (!prev_sclk && sclk) begin
      rises++;
      if (rises == 1) d_first = n - last_rise;
      else if (n - last_rise != 2*HALF) period_bad++;
      last_rise = n;
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_valid();
    int t = 0;
    while (!valid && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (!valid) chk("R5 valid timeout", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_no", cs_n, 1);
    chk("R1 sclk_o", sclk, 0);
    chk("R1 valid_o", valid, 0);
    chk("R1 busy_o", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 frame_err_o", ferr, 0);

    for (int i = 0; i < NV; i++) begin
      model_word = VEC[i];
      pulse_start();
      chk("R9 busy in frame", busy, 1);
      wait_valid();
      chk("R5 data_o", data, VEC[i][11:0]);
      chk("R6 frame_err_o", ferr, (VEC[i][15:12] != 0) ? 1 : 0);
      chk("R5 cs high at valid", cs_n, 1);
      chk("R4 rising edges", rises, 16);
      chk("R2 sclk low at cs fall", sclk_at_fall, 0);
      chk("R2 first edge delay", d_first, HALF);
      chk("R3 sclk period", period_bad, 0);
      @(negedge clk);
      chk("R5 valid one cycle", valid, 0);
      chk("R5 data held", data, VEC[i][11:0]);
      chk("R9 busy in gap", busy, 1);
      repeat (GAP + 2) @(negedge clk);
      chk("R9 idle after gap", busy, 0);
      chk("R3 sclk idle", sclk, 0);
    end

    // R8 back-to-back: requests during a frame, one extra frame only
    begin
      int f0, v0;
      f0 = fall_cnt;
      v0 = valid_cnt;
      model_word = 16'h0321;
      pulse_start();
      while (fall_cnt == f0) @(negedge clk);
      model_word = 16'h2C3D;
      repeat (40) @(negedge clk);
      pulse_start();
      repeat (20) @(negedge clk);
      pulse_start();
      wait_valid();
      chk("R8 first frame data", data, 12'h321);
      chk("R6 first frame ok", ferr, 0);
      pulse_start();  // arrives in gap, still pending frame only
      @(negedge clk);
      wait_valid();
      chk("R8 second frame data", data, 12'hC3D);
      chk("R6 second frame err", ferr, 1);
      chk("R7 cs min high", (last_hi >= GAP) ? 1 : 0, 1);
      repeat (1500) @(negedge clk);
      chk("R8 frame count", fall_cnt - f0, 2);
      chk("R8 valid count", valid_cnt - v0, 2);
      chk("R8 idle at end", busy, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule